// File: doc/BRIEF.md
# Lock-to-Sync Cascaded Delay Timer

This block enforces a long, fixed wait between a transceiver reporting lock and the moment a downstream initialization controller may start its sync step. The wait must be at least 12,000 cycles of a stable local clock. That clock must be a system or user clock, never a clock recovered from the transceiver, because a recovered clock can change while the transceiver is held in reset.

No wide binary counter is used. A single token is loaded into a chain of four recirculating shift stages. The first stage advances on every cycle. Each later stage advances only when the stage before it passes its token out of its last position, so the stage lengths multiply. The default stage lengths are 16, 16, 16 and 3, which gives 12,288 cycles. A final flip-flop captures the last stage's output and drives the done level. The lock input comes from another clock domain, so it is synchronized with two flops. A one-cycle pulse, made from the rising edge of the synchronized lock, loads the token.

Top module: `lock_delay_timer`

## Requirements
- R1: The lock input passes through two flops in the local clock domain. A single-cycle start pulse is made from the rising edge of the synchronized level. A lock that is held high produces exactly one pulse.
- R2: The chain delay is STAGE_LEN^FULL_STAGES × LAST_TAP cycles, which is 16×16×16×3 = 12,288 by default. Count edge 1 as the first clock edge that samples lock high. Then done is low after edge 12,290 and high after edge 12,291, which is 12,288 cycles plus 3 cycles of synchronizer, edge and capture latency. Each stage holds at most one token.
- R3: Once done is high, it stays high for as long as the synchronized lock stays high.
- R4: When the synchronized lock is low, all stages and done are cleared. If lock is sampled low at edge 1, done is still high after edges 1 and 2 and is low after edge 3. While lock stays low, done stays low.
- R5: A lock dropout during the wait discards the partial count. Done rises exactly 12,291 edges after the first edge that samples lock high again.
- R6: The synchronous active-high reset clears done in the same edge. If lock is held high through reset, the full count restarts from the first edge after reset is released, with the same 12,291-edge latency.
- R7: The length of the last stage, LAST_TAP, is a parameter, so the total delay can be trimmed in steps of STAGE_LEN^FULL_STAGES cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Stable local clock. |
| rst | input | 1 | Synchronous reset, active high. |
| lock_async | input | 1 | Lock level from the transceiver clock domain. |
| done | output | 1 | High once the full wait has elapsed since the latest lock rising edge. |

## Verification
The hardest conditions to reach from the ports are a dropout deep into the count, and a reset taken while lock stays high. In both, the design must restart the whole count rather than resume the partial one. The stimulus drops lock at cycle 5,000 for one cycle and at cycle 12,000 for two cycles. It then checks that done first rises exactly 12,291 edges after lock returns. It also asserts reset after done is high while lock is held, and expects a second full-length count after release.

// File: rtl/lock_delay_pkg.sv
package lock_delay_pkg;

    // State of the lock synchronizer: two capture flops plus the
    // previous stable value for edge detection.
    typedef struct packed {
        logic meta;
        logic stable;
        logic prev;
    } lock_sync_t;

    // Length of stage idx: full stages use base_len, the final one uses tap.
    function automatic int unsigned stage_length(
        input int unsigned idx,
        input int unsigned base_len,
        input int unsigned full_cnt,
        input int unsigned tap
    );
        return (idx < full_cnt) ? base_len : tap;
    endfunction

endpackage

// File: rtl/lock_edge_sync.sv
module lock_edge_sync
    import lock_delay_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lock_async,
    output logic lock_lvl,
    output logic start_pulse
);

    lock_sync_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.meta   <= lock_async;
            st_q.stable <= st_q.meta;
            st_q.prev   <= st_q.stable;
        end
    end

    assign lock_lvl    = st_q.stable;
    assign start_pulse = st_q.stable & ~st_q.prev;

    // R1: a held lock never yields two pulses in a row
    assert_single_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

endmodule

// File: rtl/token_shift_stage.sv
module token_shift_stage #(
    parameter int unsigned LEN = 16
) (
    input  logic clk,
    input  logic clr,
    input  logic load,
    input  logic en,
    output logic fire
);

    logic [LEN-1:0] ring_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            ring_q <= '0;
        end else if (load) begin
            ring_q <= {{(LEN-1){1'b0}}, 1'b1};
        end else if (en) begin
            ring_q <= {ring_q[LEN-2:0], ring_q[LEN-1]};
        end
    end

    // Token leaves the last slot on an enabled shift.
    assign fire = en & ring_q[LEN-1];

    // R2: each stage carries at most one token
    assert_one_token_R2: assert property (@(posedge clk) disable iff (clr)
        $onehot0(ring_q));

endmodule

// File: rtl/lock_delay_timer.sv
module lock_delay_timer
    import lock_delay_pkg::*;
#(
    parameter int unsigned STAGE_LEN   = 16,
    parameter int unsigned FULL_STAGES = 3,
    parameter int unsigned LAST_TAP    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic lock_async,
    output logic done
);

    localparam int unsigned NSTAGE = FULL_STAGES + 1;

    logic              lock_lvl;
    logic              start_pulse;
    logic              chain_clr;
    logic [NSTAGE-1:0] stage_en;
    logic [NSTAGE-1:0] stage_fire;
    logic              done_q;

    lock_edge_sync sync_i (
        .clk         (clk),
        .rst         (rst),
        .lock_async  (lock_async),
        .lock_lvl    (lock_lvl),
        .start_pulse (start_pulse)
    );

    assign chain_clr = rst | ~lock_lvl;

    assign stage_en[0] = 1'b1;

    for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
        if (i > 0) begin : g_link
            assign stage_en[i] = stage_fire[i-1];
        end
        token_shift_stage #(
            .LEN (stage_length(i, STAGE_LEN, FULL_STAGES, LAST_TAP))
        ) stage_i (
            .clk  (clk),
            .clr  (chain_clr),
            .load (start_pulse),
            .en   (stage_en[i]),
            .fire (stage_fire[i])
        );
    end

    // Capture flop after the last stage; sticky until lock drops.
    always_ff @(posedge clk) begin
        if (chain_clr) begin
            done_q <= 1'b0;
        end else if (stage_fire[NSTAGE-1]) begin
            done_q <= 1'b1;
        end
    end

    assign done = done_q;

    // R4: a low synchronized lock forces done low on the next edge
    assert_clear_on_drop_R4: assert property (@(posedge clk) disable iff (rst)
        !lock_lvl |=> !done);

    // R3: done holds while synchronized lock holds
    assert_done_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (done && lock_lvl) |=> done);

    // R2: done only rises after the last stage emits its token
    assert_rise_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(stage_fire[NSTAGE-1]));

    // R6: reset clears done in the same edge
    assert_reset_clear_R6: assert property (@(posedge clk)
        $past(rst) |-> !done);

endmodule

// File: tb/lock_delay_timer_tb.sv
`timescale 1ns/1ps
module lock_delay_timer_tb_top;

    localparam int CHAIN     = 16 * 16 * 16 * 3;
    localparam int EXP_RISE  = CHAIN + 3;
    localparam int NVEC      = 3;
    localparam int DROP_AT  [NVEC] = '{0, 5000, 12000};
    localparam int DROP_LEN [NVEC] = '{0, 1, 2};
    localparam int WATCHDOG  = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lock_async = 1'b0;
    logic done;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    lock_delay_timer dut_i (
        .clk        (clk),
        .rst        (rst),
        .lock_async (lock_async),
        .done       (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Raise lock, optionally drop it once, and return the edge of first done.
    task automatic run_count(input int drop_at, input int drop_len, output int rise);
        int n = 0;
        bit dropped = 1'b0;
        rise = 0;
        lock_async = 1'b1;
        while (n < EXP_RISE + 2) begin
            step();
            n++;
            if (done && rise == 0) rise = n;
            if (drop_at != 0 && !dropped && n == drop_at) begin
                lock_async = 1'b0;
                for (int k = 0; k < drop_len; k++) step();
                lock_async = 1'b1;
                dropped = 1'b1;
                n = 0;
                rise = 0;
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG && !finished) begin
                bad++;
                total++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        int rise;
        @(negedge clk);
        step();
        step();
        check(done == 1'b0, "R6 reset state", done, 0);
        rst = 1'b0;

        // R4: lock held low keeps done low
        for (int k = 0; k < 20; k++) step();
        check(done == 1'b0, "R4 idle with lock low", done, 0);

        // Vector table: plain counts and dropouts (R1, R2, R5, R3)
        for (int v = 0; v < NVEC; v++) begin
            lock_async = 1'b0;
            for (int k = 0; k < 4; k++) step();
            run_count(DROP_AT[v], DROP_LEN[v], rise);
            check(rise == EXP_RISE, (v == 0) ? "R2 R1 exact rise" : "R5 restart after dropout",
                  rise, EXP_RISE);
            check(done == 1'b1, "R3 done held after rise", done, 1);
        end

        // R3: long hold with lock high
        for (int k = 0; k < 200; k++) step();
        check(done == 1'b1, "R3 hold 200 cycles", done, 1);

        // R4: drop lock, done falls after third edge
        lock_async = 1'b0;
        step();
        step();
        check(done == 1'b1, "R4 done after 2 edges", done, 1);
        step();
        check(done == 1'b0, "R4 done after 3 edges", done, 0);

        // R6: reset while lock high and done high, then recount; R7 default tap
        lock_async = 1'b1;
        run_count(0, 0, rise);
        check(rise == EXP_RISE, "R7 tap-3 chain length", rise, EXP_RISE);
        rst = 1'b1;
        step();
        check(done == 1'b0, "R6 reset clears done", done, 0);
        step();
        rst = 1'b0;
        run_count(0, 0, rise);
        check(rise == EXP_RISE, "R6 recount after reset", rise, EXP_RISE);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule